// File: doc/BRIEF.md
# Exhaustive Shortest Closed Tour Search

This block finds the length of the shortest closed tour through `N_CITY` cities by scoring every possible visiting order. A host first streams the full directed distance matrix into the block over a valid/ready input. A one-cycle start pulse then launches the search. City 0 always opens and closes the tour, so only the orderings of the other `N_CITY-1` cities are enumerated. A new ordering is produced each clock cycle and fully scored in a short pipeline, which gives a search time of (N_CITY-1)! cycles plus a fixed drain.

All legs of a candidate tour are read in the same cycle. The block keeps one private copy of the matrix for each leg of the tour, and every copy is written together during loading. A running minimum follows the adder stage. When the final ordering leaves the pipeline, the minimum appears on the result port with a one-cycle done pulse. It stays there until the next search finishes.

Top module: `tour_min_search`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `s_tready` is 1, `done` is 0 and `best_len` is 0.
- R2: While no search is running, each cycle with `s_tvalid` high stores `s_tdata` at the load pointer. Entry index from*N_CITY+to holds the distance from city `from` to city `to`. The pointer starts at 0, wraps from N_CITY*N_CITY-1 back to 0, and returns to 0 when a search is launched.
- R3: A `start` pulse while idle launches a search, and `s_tready` stays 0 until `done`. During a search, `start` and `s_tvalid` have no effect on timing, result or the stored matrix.
- R4: The length of ordering p1..p(N-1) is d[0][p1] + d[p1][p2] + ... + d[p(N-1)][0], using directed entries, so the matrix may be asymmetric.
- R5: `best_len` reports the minimum length over all (N_CITY-1)! orderings with city 0 fixed as the start.
- R6: `done` is high for exactly one cycle. It first reads high (N_CITY-1)!+2 cycles after the clock edge that samples `start`, and `best_len` carries the new result in that same cycle.
- R7: `best_len` changes only in a cycle where `done` is high, and it holds its value until the next search completes.
- R8: Every ordering of cities 1..N_CITY-1 is produced exactly once per search, and each one is a true permutation.
- R9: The sum is `ACC_W` bits wide. With the default of 20 bits, a 13-city tour of all-maximum 16-bit distances does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | DIST_W | Distance word being loaded |
| s_tvalid | input | 1 | Distance word present |
| s_tready | output | 1 | Block is idle and accepts distance words |
| start | input | 1 | One-cycle pulse that launches the search |
| done | output | 1 | One-cycle pulse when the result is valid |
| best_len | output | ACC_W | Shortest tour length found |

## Verification
The hardest condition to create from the ports is one where a single missing or repeated ordering changes the answer. A random matrix almost never exposes it, because many orderings score near the minimum. To reach it, the bench builds one matrix for each of the (N_CITY-1)! orderings of a five-city case. In each matrix, the directed legs of the chosen ordering cost 1 and every other entry costs 500, so exactly one ordering can reach the minimum of 5. The load pointer and its wrap are driven into unusual alignments by sending extra words, or by cutting a load short with a start pulse.

// File: rtl/tour_pkg.sv
package tour_pkg;

  function automatic longint unsigned fact(input int n);
    longint unsigned f;
    f = 1;
    for (int i = 2; i <= n; i++) f = f * longint'(i);
    return f;
  endfunction

endpackage

// File: rtl/dist_bank.sv
module dist_bank #(
  parameter int N_CITY = 13,
  parameter int DIST_W = 16,
  parameter int NN     = N_CITY * N_CITY,
  parameter int AW     = $clog2(NN)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DIST_W-1:0] wdata,
  input  logic [AW-1:0]     raddr [N_CITY],
  output logic [DIST_W-1:0] rdata [N_CITY]
);

  for (genvar k = 0; k < N_CITY; k++) begin : g_copy
    logic [DIST_W-1:0] mem [NN];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata[k] <= mem[raddr[k]];
    end
  end

endmodule

// File: rtl/perm_engine.sv
module perm_engine
  import tour_pkg::*;
#(
  parameter int N_CITY = 13,
  parameter int M      = N_CITY - 1,
  parameter int CW     = $clog2(N_CITY)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  output logic [CW-1:0] perm [M],
  output logic          valid,
  output logic          last
);

  localparam longint unsigned FACT_M = fact(M);

  logic [CW-1:0] perm_q [M];
  logic [CW-1:0] c_q    [M];
  logic [CW-1:0] nxt_p  [M];
  logic [CW-1:0] nxt_c  [M];
  logic [CW-1:0] sel, other;
  logic          has_next;

  // Heap's method, with the index search folded into one cycle
  always_comb begin
    nxt_p    = perm_q;
    nxt_c    = c_q;
    has_next = 1'b0;
    sel      = '0;
    other    = '0;
    for (int i = 1; i < M; i++) begin
      if (!has_next && c_q[i] < CW'(i)) begin
        has_next = 1'b1;
        sel      = CW'(i);
      end
    end
    if (has_next) begin
      for (int j = 1; j < M; j++)
        if (CW'(j) < sel) nxt_c[j] = '0;
      nxt_c[sel]   = c_q[sel] + 1'b1;
      other        = sel[0] ? c_q[sel] : '0;
      nxt_p[sel]   = perm_q[other];
      nxt_p[other] = perm_q[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      for (int j = 0; j < M; j++) begin
        perm_q[j] <= CW'(j + 1);
        c_q[j]    <= '0;
      end
    end else if (launch) begin
      valid <= 1'b1;
      for (int j = 0; j < M; j++) begin
        perm_q[j] <= CW'(j + 1);
        c_q[j]    <= '0;
      end
    end else if (valid) begin
      if (has_next) begin
        perm_q <= nxt_p;
        c_q    <= nxt_c;
      end else begin
        valid <= 1'b0;
      end
    end
  end

  assign perm = perm_q;
  assign last = valid && !has_next;

  // checker state: permutation legality and emission count
  logic [N_CITY-1:0] seen;
  logic [63:0]       emit_cnt;
  always_comb begin
    seen = '0;
    for (int j = 0; j < M; j++) seen[perm_q[j]] = 1'b1;
  end
  always_ff @(posedge clk) begin
    if (rst || launch) emit_cnt <= '0;
    else if (valid)    emit_cnt <= emit_cnt + 1'b1;
  end

  AST_PERM_LEGAL: assert property (@(posedge clk) disable iff (rst)
    valid |-> (seen == {{(N_CITY-1){1'b1}}, 1'b0}));                // R8
  AST_PERM_COUNT: assert property (@(posedge clk) disable iff (rst)
    (valid && last) |-> (emit_cnt == FACT_M - 1));                  // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (valid && last && !launch) |=> !valid);                         // R8

endmodule

// File: rtl/route_scorer.sv
module route_scorer #(
  parameter int N_CITY = 13,
  parameter int DIST_W = 16,
  parameter int ACC_W  = 20,
  parameter int M      = N_CITY - 1,
  parameter int CW     = $clog2(N_CITY),
  parameter int NN     = N_CITY * N_CITY,
  parameter int AW     = $clog2(NN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DIST_W-1:0] wdata,
  input  logic [CW-1:0]     perm [M],
  input  logic              in_valid,
  input  logic              in_last,
  output logic [ACC_W-1:0]  sum,
  output logic              sum_valid,
  output logic              sum_last
);

  logic [AW-1:0]     raddr [N_CITY];
  logic [DIST_W-1:0] leg   [N_CITY];
  logic              v1, l1;
  logic [ACC_W-1:0]  total;

  // leg k runs from stop k to stop k+1; stop 0 and stop N are city 0
  for (genvar k = 0; k < N_CITY; k++) begin : g_leg
    logic [CW-1:0] from_c, to_c;
    if (k == 0) begin : g_first
      assign from_c = '0;
      assign to_c   = perm[0];
    end else if (k == M) begin : g_back
      assign from_c = perm[M-1];
      assign to_c   = '0;
    end else begin : g_mid
      assign from_c = perm[k-1];
      assign to_c   = perm[k];
    end
    assign raddr[k] = AW'(from_c) * AW'(N_CITY) + AW'(to_c);
  end

  dist_bank #(.N_CITY(N_CITY), .DIST_W(DIST_W)) u_bank (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (leg)
  );

  always_comb begin
    total = '0;
    for (int k = 0; k < N_CITY; k++) total = total + ACC_W'(leg[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; l1 <= 1'b0;
      sum_valid <= 1'b0; sum_last <= 1'b0; sum <= '0;
    end else begin
      v1 <= in_valid;
      l1 <= in_valid && in_last;
      sum_valid <= v1;
      sum_last  <= l1;
      sum       <= total;
    end
  end

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    sum_last |-> sum_valid);                                        // R6

endmodule

// File: rtl/tour_min_search.sv
module tour_min_search #(
  parameter int N_CITY = 13,
  parameter int DIST_W = 16,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIST_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              start,
  output logic              done,
  output logic [ACC_W-1:0]  best_len
);

  localparam int M  = N_CITY - 1;
  localparam int CW = $clog2(N_CITY);
  localparam int NN = N_CITY * N_CITY;
  localparam int AW = $clog2(NN);

  logic             busy, launch, we;
  logic [AW-1:0]    wptr;
  logic [CW-1:0]    perm [M];
  logic             p_valid, p_last;
  logic [ACC_W-1:0] sum, run_min, nxt_min;
  logic             sum_valid, sum_last;

  assign launch   = start && !busy;
  assign we       = s_tvalid && !busy;
  assign s_tready = !busy;

  perm_engine #(.N_CITY(N_CITY)) u_perm (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .perm   (perm),
    .valid  (p_valid),
    .last   (p_last)
  );

  route_scorer #(.N_CITY(N_CITY), .DIST_W(DIST_W), .ACC_W(ACC_W)) u_score (
    .clk       (clk),
    .rst       (rst),
    .we        (we),
    .waddr     (wptr),
    .wdata     (s_tdata),
    .perm      (perm),
    .in_valid  (p_valid),
    .in_last   (p_last),
    .sum       (sum),
    .sum_valid (sum_valid),
    .sum_last  (sum_last)
  );

  // strict less-than keeps the earliest of equal minima
  assign nxt_min = (sum < run_min) ? sum : run_min;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      wptr     <= '0;
      run_min  <= '1;
      best_len <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy    <= 1'b1;
        wptr    <= '0;
        run_min <= '1;
      end else if (we) begin
        wptr <= (wptr == AW'(NN - 1)) ? '0 : wptr + 1'b1;
      end
      if (sum_valid) begin
        run_min <= nxt_min;
        if (sum_last) begin
          best_len <= nxt_min;
          done     <= 1'b1;
          busy     <= 1'b0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                // R6
  AST_BEST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(best_len) |-> done);                                   // R7
  AST_MIN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (busy && !launch) |=> (run_min <= $past(run_min)));             // R5
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    wptr < AW'(NN));                                                // R2

endmodule

// File: tb/tour_min_search_bench.sv
module tour_min_search_bench;
  localparam int N    = 5;
  localparam int NN   = N * N;
  localparam int DW   = 16;
  localparam int AW_  = 20;
  localparam int PERMS = 24;

  logic clk = 0, rst = 1;
  logic [DW-1:0]  s_tdata = '0;
  logic           s_tvalid = 0, start = 0;
  logic           s_tready, done;
  logic [AW_-1:0] best_len;

  int tests = 0, fails = 0;
  int m [NN];
  int ptr = 0;
  int ord [PERMS][4];

  always #2 clk = ~clk;

  tour_min_search #(.N_CITY(N), .DIST_W(DW), .ACC_W(AW_)) u_tour_min_search (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .start(start), .done(done), .best_len(best_len)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int v);
    s_tvalid = 1; s_tdata = DW'(v);
    @(posedge clk); #1;
    s_tvalid = 0;
    m[ptr] = v;
    ptr = (ptr + 1) % NN;
  endtask

  task automatic load_all();
    for (int i = 0; i < NN; i++) send(m[i]);
  endtask

  function automatic int model_best();
    int b, len;
    b = 32'h7fffffff;
    for (int a = 1; a < N; a++)
      for (int bb = 1; bb < N; bb++)
        for (int c = 1; c < N; c++)
          for (int d = 1; d < N; d++)
            if (a != bb && a != c && a != d && bb != c && bb != d && c != d) begin
              len = m[a] + m[a*N+bb] + m[bb*N+c] + m[c*N+d] + m[d*N];
              if (len < b) b = len;
            end
    return b;
  endfunction

  // disturb=1: pulse start and drive tvalid junk during the search (R3)
  task automatic run(input string req, input bit disturb);
    int cnt, exp;
    exp = model_best();
    start = 1; @(posedge clk); #1; start = 0;
    ptr = 0;
    cnt = 0;
    while (!done && cnt < 200) begin
      @(posedge clk); #1; cnt++;
      if (cnt == 3) check("R3 tready low in search", s_tready, 0);
      if (disturb && cnt == 5) begin start = 1; s_tvalid = 1; s_tdata = 16'h0; end
      if (disturb && cnt == 9) begin start = 0; s_tvalid = 0; end
    end
    check({req, " R5 best"}, best_len, exp);
    check("R6 done latency", cnt, PERMS + 2);
    @(posedge clk); #1;
    check("R6 done one cycle", done, 0);
    check("R3 tready back", s_tready, 1);
  endtask

  int seed = 32'h1234_5678;
  function automatic int rnd(input int lim);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffff) % lim;
  endfunction

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    k = 0;
    for (int a = 1; a < N; a++)
      for (int b = 1; b < N; b++)
        for (int c = 1; c < N; c++)
          for (int d = 1; d < N; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              ord[k][0] = a; ord[k][1] = b; ord[k][2] = c; ord[k][3] = d; k++;
            end
    repeat (3) @(posedge clk);
    #1;
    check("R1 tready in reset", s_tready, 1);
    check("R1 done in reset", done, 0);
    rst = 0;
    @(posedge clk); #1;
    check("R1 tready", s_tready, 1);
    check("R1 done", done, 0);
    check("R1 best", best_len, 0);

    // random matrix
    for (int i = 0; i < NN; i++) m[i] = rnd(1000);
    load_all();
    run("random", 0);

    // R7 hold after done
    begin
      int held;
      held = int'(best_len);
      repeat (20) @(posedge clk);
      #1;
      check("R7 best held", best_len, held);
    end

    // R4 asymmetric: only route 0-3-1-4-2-0 is cheap one way
    for (int i = 0; i < NN; i++) m[i] = 1000;
    m[0*N+3] = 1; m[3*N+1] = 1; m[1*N+4] = 1; m[4*N+2] = 1; m[2*N+0] = 1;
    load_all();
    run("R4 directed", 0);
    check("R4 directed len", best_len, 5);

    // R9 all-max distances, no wrap
    for (int i = 0; i < NN; i++) m[i] = 65535;
    load_all();
    run("R9 max", 0);
    check("R9 no wrap", best_len, 5 * 65535);

    // R3 start and tvalid ignored during search
    for (int i = 0; i < NN; i++) m[i] = 10 + rnd(300);
    load_all();
    run("R3 disturbed", 1);

    // R2 wrap: two extra words overwrite entries 0 and 1
    for (int i = 0; i < NN; i++) m[i] = 20 + rnd(200);
    load_all();
    send(3); send(7);
    run("R2 wrap", 0);

    // R2 start returns pointer to 0: partial load then full reload
    send(1); send(2); send(4);
    run("R2 partial", 0);
    for (int i = 0; i < NN; i++) m[i] = 5 + rnd(900);
    load_all();
    run("R2 reload", 0);

    // R8 each ordering alone reaches the minimum
    for (int p = 0; p < PERMS; p++) begin
      for (int i = 0; i < NN; i++) m[i] = 500;
      m[ord[p][0]] = 1;
      m[ord[p][0]*N + ord[p][1]] = 1;
      m[ord[p][1]*N + ord[p][2]] = 1;
      m[ord[p][2]*N + ord[p][3]] = 1;
      m[ord[p][3]*N] = 1;
      load_all();
      run("R8 ordering", 0);
      check("R8 unique route found", best_len, 5);
    end

    // more random matrices
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < NN; i++) m[i] = rnd(65536);
      load_all();
      run("R5 random", 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule